// File: doc/BRIEF.md
# Block-Write Serial Register Slave

A two-wire serial slave (I2C signalling) that owns a bank of thirteen 8-bit control registers and presents all of them in parallel to the surrounding logic. It has no register pointer. A write transaction carries the slave address, then two filler bytes in the manner of an SMBus block write (a command code and a byte count). Both filler bytes are acknowledged and thrown away. Every byte after them lands in the next register, beginning at register 0, until the master issues STOP.

A read transaction needs no preamble. Right after the address acknowledge the slave shifts out register 0, then 1, 2 and onward for as long as the master acknowledges. Two registers hold fixed identification values. One bit of register 6 is a live status bit that comes from outside the bank. Both bus lines pass through a two-flop synchroniser into the system clock domain. SDA is driven with an open-drain enable only: the slave pulls the line low when the enable is set and otherwise leaves it released.

Top module: `blkwr_reg_slave`

## Requirements
- R1: The first byte after START is a 7-bit address followed by a R/W bit (1 = read). The slave pulls SDA low in the ninth clock only when the address equals DEV_ADDR (default 7'h69). On a mismatch it never drives SDA and writes nothing until the next START.
- R2: In a write, the two bytes after the address are acknowledged, and their values change no register.
- R3: In a write, the third and later bytes after the address go to registers 0, 1, 2, … in turn, and each is acknowledged. The byte appears on `regs_o[8*i +: 8]` for register i.
- R4: In a read, the slave shifts out register 0 first, most significant bit first, then the following registers in order while the master acknowledges.
- R5: After reset, `regs_o` holds these values, listed by register index: 0=0x00, 1=0xCF, 2=0xFF, 3=0xFF, 4=0x00, 5=0x93, 6=0x00, 7=0x40, 8=0x00, 9=0x00, 10=0x00, 11=0x05, 12=0x31. `sda_oe` is 0.
- R6: Registers 11 and 12 always read 0x05 and 0x31. Writes to them are acknowledged and leave them unchanged.
- R7: Bit 6 of register 6 is read-only. On a read it returns `stat_i`. A write leaves it 0 in `regs_o`, while the other bits of register 6 take the written value.
- R8: When the master answers a read byte with NACK, the slave releases SDA and keeps it released until the next START.
- R9: Write bytes that target index 13 or above are acknowledged and ignored. Read bytes at index 13 or above return 0xFF.
- R10: A STOP or a repeated START at any point sends the slave back to waiting for an address. A new write after it again skips two filler bytes and restarts at register 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin |
| stat_i | input | 1 | Live status bit, returned as bit 6 of register 6 |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| regs_o | output | 104 | All registers, register i in bits 8*i+7 down to 8*i |

## Verification
Each bus edge reaches the slave logic two clocks after it appears at a pin. The slave then acts on the third rising clock edge after the pin change. A written register therefore changes on the third edge after the SCL fall that ends its eighth data bit, and the slave's drive on SDA changes on the third edge after an SCL fall. The bench records a due cycle of exactly three edges for every write it expects. It compares its own register model against `regs_o` on every falling clock edge, so an early or a late update is reported as a failure. The bench samples SDA only halfway through SCL high, long after the three-cycle lag has passed, and checks each ACK and read bit at that point.

// File: rtl/blkwr_pkg.sv
package blkwr_pkg;

  localparam int REG_COUNT = 13;
  localparam int IDXW      = $clog2(REG_COUNT + 1);
  localparam int STAT_REG  = 6;
  localparam int STAT_BIT  = 6;
  localparam int FILLER_BYTES = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_TACK
  } bus_state_e;

  // value after reset (identification registers keep it forever)
  function automatic logic [7:0] reg_default(input int i);
    case (i)
      1:       return 8'hCF;
      2, 3:    return 8'hFF;
      5:       return 8'h93;
      7:       return 8'h40;
      11:      return 8'h05;
      12:      return 8'h31;
      default: return 8'h00;
    endcase
  endfunction

  // bits a write may change
  function automatic logic [7:0] reg_wmask(input int i);
    if (i == 11 || i == 12) return 8'h00;
    if (i == STAT_REG)      return ~(8'h01 << STAT_BIT);
    return 8'hFF;
  endfunction

  function automatic logic [IDXW-1:0] sat_inc(input logic [IDXW-1:0] p);
    return (p == IDXW'(REG_COUNT)) ? p : p + 1'b1;
  endfunction

  function automatic logic addr_match(input logic [7:0] b, input logic [6:0] dev);
    return b[7:1] == dev;
  endfunction

endpackage

// File: rtl/blkwr_line_sync.sv
module blkwr_line_sync #(
  parameter int STAGES = 2   // at least 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  assign scl_s    = scl_pipe[STAGES-1];
  assign sda_s    = sda_pipe[STAGES-1];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/blkwr_byte_engine.sv
module blkwr_byte_engine
  import blkwr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sda_s,
  input  logic            scl_rise,
  input  logic            scl_fall,
  input  logic            start_ev,
  input  logic            stop_ev,
  input  logic [7:0]      rd_byte,
  output logic            sda_oe,
  output logic            wr_en,
  output logic [IDXW-1:0] reg_idx,
  output logic [7:0]      wr_data,
  output logic            addr_miss,
  output logic            nack_ev
);
  bus_state_e      state;
  logic [3:0]      bitcnt;
  logic [7:0]      shreg;
  logic            rw, addr_ph;
  logic [1:0]      fcnt;
  logic [IDXW-1:0] ptr;
  logic            byte_in;

  assign byte_in   = (state == ST_RX) && scl_fall && (bitcnt == 4'd8);
  assign addr_miss = byte_in && addr_ph && !addr_match(shreg, DEV_ADDR);
  assign wr_en     = byte_in && !addr_ph && (fcnt == 2'(FILLER_BYTES))
                     && (ptr != IDXW'(REG_COUNT));
  assign nack_ev   = (state == ST_TACK) && scl_rise && sda_s;
  assign wr_data   = shreg;
  assign reg_idx   = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bitcnt  <= '0;
      shreg   <= '0;
      rw      <= 1'b0;
      addr_ph <= 1'b0;
      fcnt    <= '0;
      ptr     <= '0;
      sda_oe  <= 1'b0;
    end else if (start_ev) begin
      state   <= ST_RX;
      bitcnt  <= '0;
      addr_ph <= 1'b1;
      fcnt    <= '0;
      ptr     <= '0;
      sda_oe  <= 1'b0;
    end else if (stop_ev) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        ST_RX: begin
          if (scl_rise && bitcnt != 4'd8) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 1'b1;
          end else if (byte_in) begin
            if (addr_ph) begin
              if (addr_match(shreg, DEV_ADDR)) begin
                sda_oe  <= 1'b1;
                rw      <= shreg[0];
                addr_ph <= 1'b0;
                state   <= ST_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              sda_oe <= 1'b1;
              state  <= ST_ACK;
              if (fcnt != 2'(FILLER_BYTES)) fcnt <= fcnt + 1'b1;
              else                          ptr  <= sat_inc(ptr);
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            if (rw) begin
              shreg  <= rd_byte;
              sda_oe <= ~rd_byte[7];
              bitcnt <= 4'd1;
              ptr    <= sat_inc(ptr);
              state  <= ST_TX;
            end else begin
              sda_oe <= 1'b0;
              bitcnt <= '0;
              state  <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bitcnt == 4'd8) begin
              sda_oe <= 1'b0;
              state  <= ST_TACK;
            end else begin
              sda_oe <= ~shreg[6];
              shreg  <= {shreg[6:0], 1'b1};
              bitcnt <= bitcnt + 1'b1;
            end
          end
        end
        ST_TACK: begin
          if (scl_rise) state <= sda_s ? ST_IDLE : ST_ACK;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/blkwr_regbank.sv
module blkwr_regbank
  import blkwr_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [IDXW-1:0]        idx,
  input  logic [7:0]             wr_data,
  input  logic                   stat_i,
  output logic [7:0]             rd_byte,
  output logic [REG_COUNT*8-1:0] regs_o
);
  for (genvar i = 0; i < REG_COUNT; i++) begin : g_reg
    localparam logic [7:0] DEF  = reg_default(i);
    localparam logic [7:0] MASK = reg_wmask(i);
    if (MASK == 8'h00) begin : g_const
      assign regs_o[8*i +: 8] = DEF;
    end else begin : g_flop
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          q <= DEF;
        else if (wr_en && idx == IDXW'(i))
          q <= (q & ~MASK) | (wr_data & MASK);
      end
      assign regs_o[8*i +: 8] = q;
    end
  end

  always_comb begin
    rd_byte = 8'hFF;
    for (int i = 0; i < REG_COUNT; i++) begin
      if (idx == IDXW'(i)) begin
        rd_byte = regs_o[8*i +: 8];
        if (i == STAT_REG) rd_byte[STAT_BIT] = stat_i;
      end
    end
  end
endmodule

// File: rtl/blkwr_reg_slave.sv
module blkwr_reg_slave
  import blkwr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   scl_i,
  input  logic                   sda_i,
  input  logic                   stat_i,
  output logic                   sda_oe,
  output logic [REG_COUNT*8-1:0] regs_o
);
  logic            sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic            wr_en, addr_miss, nack_ev;
  logic [IDXW-1:0] reg_idx;
  logic [7:0]      wr_data, rd_byte;

  blkwr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  blkwr_byte_engine #(.DEV_ADDR(DEV_ADDR)) u_eng (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
    .rd_byte(rd_byte), .sda_oe(sda_oe), .wr_en(wr_en), .reg_idx(reg_idx),
    .wr_data(wr_data), .addr_miss(addr_miss), .nack_ev(nack_ev)
  );

  blkwr_regbank u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .idx(reg_idx),
    .wr_data(wr_data), .stat_i(stat_i), .rd_byte(rd_byte), .regs_o(regs_o)
  );
endmodule

// File: rtl/blkwr_reg_slave_chk.sv
module blkwr_reg_slave_chk
  import blkwr_pkg::*;
(
  input logic                   clk,
  input logic                   rst_n,
  input logic                   sda_oe,
  input logic [REG_COUNT*8-1:0] regs_o,
  input logic                   start_ev,
  input logic                   addr_miss,
  input logic                   nack_ev,
  input logic                   wr_en,
  input logic [IDXW-1:0]        reg_idx,
  input logic [7:0]             wr_data
);
  // R1: a foreign address is never acknowledged
  a_r1_miss_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    addr_miss |=> !sda_oe);

  // R3: a write strobe to register 0 lands there one clock later
  a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_idx == '0) |=> regs_o[7:0] == $past(wr_data));

  // R7: the status position in the stored register never picks up data
  a_r7_status_not_stored: assert property (@(posedge clk) disable iff (!rst_n)
    !regs_o[8*STAT_REG + STAT_BIT]);

  // R8: NACK from the master releases the line
  a_r8_release_after_nack: assert property (@(posedge clk) disable iff (!rst_n)
    nack_ev |=> !sda_oe);

  // R9: no write strobe beyond the last register
  a_r9_no_write_past_end: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> reg_idx < IDXW'(REG_COUNT));

  // R10: START puts the slave back into listening
  a_r10_start_releases: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> !sda_oe);
endmodule

bind blkwr_reg_slave blkwr_reg_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .regs_o(regs_o),
  .start_ev(start_ev), .addr_miss(addr_miss), .nack_ev(nack_ev),
  .wr_en(wr_en), .reg_idx(reg_idx), .wr_data(wr_data)
);

// File: tb/test_blkwr_reg_slave.sv
`timescale 1ns/1ps
module test_blkwr_reg_slave;
  localparam int NREG = 13;
  localparam int H = 8;
  localparam logic [6:0] DEV = 7'h69;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, stat_i = 1'b1;
  logic sda_oe;
  logic [NREG*8-1:0] regs_o;
  wire  sda_line = sda_m & ~sda_oe;

  blkwr_reg_slave i_blkwr_reg_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .stat_i(stat_i), .sda_oe(sda_oe), .regs_o(regs_o)
  );

  always #5 clk = ~clk;

  int nchk = 0, nfail = 0, cyc = 0;
  logic [7:0] mdl [NREG];
  bit pend = 0; int pend_due, pend_idx; logic [7:0] pend_val;
  bit run_cmp = 0;

  always @(posedge clk) cyc++;

  task automatic check(string r, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic logic [7:0] keep_bits(int i);
    if (i == 11 || i == 12) return 8'h00;
    if (i == 6) return 8'hBF;
    return 8'hFF;
  endfunction

  function automatic logic [7:0] exp_rd(int i);
    logic [7:0] v;
    if (i >= NREG) return 8'hFF;
    v = mdl[i];
    if (i == 6) v[6] = stat_i;
    return v;
  endfunction

  // per-clock comparison of the register outputs with the model (R3, R6, R7, R9)
  always @(negedge clk) begin
    if (pend && cyc >= pend_due) begin
      if (pend_idx < NREG)
        mdl[pend_idx] = (mdl[pend_idx] & ~keep_bits(pend_idx)) | (pend_val & keep_bits(pend_idx));
      pend = 0;
    end
    if (run_cmp) begin
      for (int i = 0; i < NREG; i++)
        if (regs_o[8*i +: 8] !== mdl[i]) begin
          nchk++; nfail++;
          $display("FAIL R3 reg%0d actual=%h expected=%h at cycle %0d", i, regs_o[8*i +: 8], mdl[i], cyc);
        end
    end
  end

  task automatic half(); repeat (H) @(negedge clk); endtask
  task automatic start_c();  sda_m = 1; scl_m = 1; half(); sda_m = 0; half(); scl_m = 0; half(); endtask
  task automatic rstart_c(); sda_m = 1; half(); scl_m = 1; half(); sda_m = 0; half(); scl_m = 0; half(); endtask
  task automatic stop_c();   sda_m = 0; half(); scl_m = 1; half(); sda_m = 1; half(); endtask

  // widx: register the byte is due in, -1 for none
  task automatic send_byte(input logic [7:0] b, input int widx, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; half(); scl_m = 1; half(); scl_m = 0;
      if (i == 0 && widx >= 0) begin
        pend_idx = widx; pend_val = b; pend_due = cyc + 3; pend = 1;
      end
    end
    sda_m = 1; half(); scl_m = 1;
    repeat (H/2) @(negedge clk);
    acked = !sda_line;
    repeat (H/2) @(negedge clk);
    scl_m = 0;
  endtask

  task automatic read_byte(input bit nack, output logic [7:0] b, output bit drove);
    drove = 0; b = '0;
    for (int i = 0; i < 8; i++) begin
      for (int k = 0; k < H; k++) begin @(negedge clk); drove |= sda_oe; end
      scl_m = 1;
      repeat (H/2) @(negedge clk);
      b = {b[6:0], sda_line};
      for (int k = 0; k < H/2; k++) begin @(negedge clk); drove |= sda_oe; end
      scl_m = 0;
    end
    sda_m = nack; half(); scl_m = 1; half(); scl_m = 0; sda_m = 1;
  endtask

  task automatic wr_txn(input logic [6:0] a, input logic [7:0] d[$], input bit do_stop);
    bit ack; bit hit = (a == DEV);
    start_c();
    send_byte({a, 1'b0}, -1, ack);
    check(hit ? "R1 address ack" : "R1 foreign address", ack, hit);
    send_byte(8'h3C, -1, ack); check("R2 filler 1 ack", ack, hit);
    send_byte(8'(d.size()), -1, ack); check("R2 filler 2 ack", ack, hit);
    foreach (d[k]) begin
      send_byte(d[k], hit ? k : -1, ack);
      check(k >= NREG ? "R9 ack past end" : "R3 data ack", ack, hit);
    end
    if (do_stop) stop_c();
  endtask

  task automatic rd_txn(input int n);
    bit ack, drove; logic [7:0] b;
    start_c();
    send_byte({DEV, 1'b1}, -1, ack); check("R1 read address ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      read_byte(k == n-1, b, drove);
      check(k >= NREG ? "R9 read past end" : (k == 6 ? "R7 status read" : "R4 read data"), b, exp_rd(k));
    end
    read_byte(1'b1, b, drove);
    check("R8 released after NACK", {drove, b}, {1'b0, 8'hFF});
    stop_c();
  endtask

  initial begin
    int lim = 150000;
    while (cyc < lim) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=%0d expected=<%0d", cyc, lim);
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    logic [7:0] q[$];
    bit ack;
    for (int i = 0; i < NREG; i++) mdl[i] = 8'h00;
    mdl[1] = 8'hCF; mdl[2] = 8'hFF; mdl[3] = 8'hFF; mdl[5] = 8'h93;
    mdl[7] = 8'h40; mdl[11] = 8'h05; mdl[12] = 8'h31;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R5 reset state
    for (int i = 0; i < NREG; i++) check("R5 reset value", regs_o[8*i +: 8], mdl[i]);
    check("R5 sda_oe idle", sda_oe, 0);
    run_cmp = 1;

    // R2 / R3: short write
    q = '{8'h11, 8'h22, 8'h33};
    wr_txn(DEV, q, 1);
    check("R3 reg0", regs_o[7:0], 8'h11);
    check("R2 reg3 untouched", regs_o[31:24], 8'hFF);

    // R4 / R7 / R9 / R8: read all plus two beyond
    stat_i = 1;
    rd_txn(NREG + 2);

    // R6 / R7 / R9: full write including ids and beyond
    q = {};
    for (int k = 0; k < NREG + 2; k++) q.push_back(8'(8'hE0 + k*7) | (k == 6 ? 8'hFF : 8'h00));
    wr_txn(DEV, q, 1);
    check("R6 id lo", regs_o[8*11 +: 8], 8'h05);
    check("R6 id hi", regs_o[8*12 +: 8], 8'h31);
    check("R7 status bit not stored", regs_o[8*6 + 6], 0);
    stat_i = 0;
    rd_txn(8);

    // R10: repeated START restarts filler counting and register 0
    q = '{8'h5A};
    wr_txn(DEV, q, 0);
    rstart_c();
    send_byte({DEV, 1'b0}, -1, ack); check("R10 address after restart", ack, 1);
    send_byte(8'h77, -1, ack); send_byte(8'h66, -1, ack);
    send_byte(8'hC3, 0, ack); check("R10 data ack", ack, 1);
    stop_c();
    check("R10 reg0 after restart", regs_o[7:0], 8'hC3);
    check("R10 filler not written", regs_o[15:8], mdl[1]);

    // R10: STOP in the middle of the filler bytes
    start_c();
    send_byte({DEV, 1'b0}, -1, ack);
    send_byte(8'h99, -1, ack);
    stop_c();
    q = '{8'h01, 8'h02};
    wr_txn(DEV, q, 1);
    check("R10 reg0 after stop", regs_o[7:0], 8'h01);

    // R1: foreign address, bytes must be ignored
    q = '{8'hAB, 8'hCD};
    wr_txn(7'h22, q, 1);
    check("R1 reg0 kept", regs_o[7:0], 8'h01);
    check("R1 released", sda_oe, 0);

    repeat (10) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule